// File: doc/BRIEF.md
# Windowed Pulse-Count Frequency Detector

This block judges whether a divided oscillator runs ahead of or behind a reference. Three single-bit lines arrive from outside the system-clock domain: the reference clock itself and the up and down trigger lines of an upstream phase detector. Each line is brought into the system clock domain and reduced to one pulse per rising edge. Separate counters then tally reference edges, up-trigger edges and down-trigger edges.

A window is a fixed number of reference edges, 14 by default. When the reference tally reaches that number, counting stops and the two trigger tallies are compared. A larger up tally raises `fast_o` and a larger down tally raises `slow_o`; equal tallies raise neither. A one-cycle `done_o` strobe marks the decision. The verdict holds until a `restart_i` pulse clears everything and opens a new window. Only the number of edges matters. The phase relation between the lines plays no part.

Top module: `fdet_window_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fast_o`, `slow_o` and `done_o` are 0, and the window is open with all three counts at zero.
- R2: Each input passes through a two-flop synchroniser and an edge register. A 0-to-1 change sampled at clock edge k is counted at edge k+2. When the reference count reaches WINDOW, `done_o` is high for exactly one cycle, one clock later. That is once per window.
- R3: At the decision, if the up count is greater than the down count, `fast_o` becomes 1 and `slow_o` becomes 0.
- R4: At the decision, if the down count is greater than the up count, `slow_o` becomes 1 and `fast_o` becomes 0.
- R5: At the decision, if the two counts are equal, both `fast_o` and `slow_o` are 0.
- R6: `fast_o` and `slow_o` are never 1 in the same cycle.
- R7: After a decision, `fast_o` and `slow_o` hold their values, and further input edges produce no new decision and no `done_o`, until `restart_i`.
- R8: A cycle with `restart_i` high clears all counts and both flags and opens a new window. Edges that would be counted in that same cycle are dropped.
- R9: Each trigger count saturates at 2^CNT_W-1 (31 by default) instead of wrapping.
- R10: Only rising edges count. A line held high for many cycles adds one to its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous pulse: clear counts and flags, open a new window |
| ref_i | input | 1 | Reference clock line, asynchronous |
| up_trig_i | input | 1 | Up-trigger line from the phase detector, asynchronous |
| dn_trig_i | input | 1 | Down-trigger line from the phase detector, asynchronous |
| fast_o | output | 1 | Verdict: up edges outnumbered down edges |
| slow_o | output | 1 | Verdict: down edges outnumbered up edges |
| done_o | output | 1 | One-cycle strobe when a verdict is taken |

## Verification
The hardest case to reach from the ports is counter saturation. Its effect can only be seen as a verdict that wrapping would flip. The bench therefore drives three up edges and two down edges per reference period. The up count passes 31 while the down count stays below it, so a wrapping counter would report slow where the correct answer is fast. A second run saturates both counters and must end in a tie. A restart in mid-window after a burst of down edges shows that stale counts are dropped. A trigger line held high through a whole window shows that levels are not counted.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    typedef enum logic [1:0] {
        VERDICT_TIE  = 2'd0,
        VERDICT_FAST = 2'd1,
        VERDICT_SLOW = 2'd2
    } verdict_e;

    typedef struct packed {
        logic active;
        logic done;
        logic fast;
        logic slow;
    } fdet_state_t;

    localparam int unsigned NUM_LINES = 3;
    localparam int unsigned LINE_REF  = 0;
    localparam int unsigned LINE_UP   = 1;
    localparam int unsigned LINE_DN   = 2;

endpackage

// File: rtl/fdet_edge_sync.sv
module fdet_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], sig_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R10
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fdet_sat_counter.sv
module fdet_sat_counter #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o
);
    localparam logic [WIDTH-1:0] TOP = '1;

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                     cnt_d = '0;
        else if (inc_i && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && !clr_i) |=> cnt_q == TOP);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);

endmodule

// File: rtl/fdet_verdict.sv
module fdet_verdict
    import fdet_pkg::*;
#(
    parameter int unsigned WIDTH = 5
) (
    input  logic [WIDTH-1:0] up_cnt_i,
    input  logic [WIDTH-1:0] dn_cnt_i,
    output verdict_e         verdict_o
);
    always_comb begin
        if (up_cnt_i > dn_cnt_i)      verdict_o = VERDICT_FAST;
        else if (dn_cnt_i > up_cnt_i) verdict_o = VERDICT_SLOW;
        else                          verdict_o = VERDICT_TIE;
    end
endmodule

// File: rtl/fdet_window_top.sv
module fdet_window_top
    import fdet_pkg::*;
#(
    parameter int unsigned WINDOW      = 14,
    parameter int unsigned CNT_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic ref_i,
    input  logic up_trig_i,
    input  logic dn_trig_i,
    output logic fast_o,
    output logic slow_o,
    output logic done_o
);
    localparam int unsigned REF_W = $clog2(WINDOW + 1);
    localparam logic [REF_W-1:0] WIN_END = REF_W'(WINDOW);

    logic [NUM_LINES-1:0] line_in;
    logic [NUM_LINES-1:0] line_rise;
    logic [REF_W-1:0]     ref_cnt;
    logic [CNT_W-1:0]     trig_cnt [2];
    logic                 count_en;
    logic                 win_full;
    verdict_e             verdict;
    fdet_state_t          st_d, st_q;

    assign line_in[LINE_REF] = ref_i;
    assign line_in[LINE_UP]  = up_trig_i;
    assign line_in[LINE_DN]  = dn_trig_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        fdet_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (line_in[g]),
            .rise_o (line_rise[g])
        );
    end

    assign win_full = (ref_cnt == WIN_END);
    assign count_en = st_q.active & ~win_full;

    fdet_sat_counter #(.WIDTH(REF_W)) ref_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (restart_i),
        .inc_i (count_en & line_rise[LINE_REF]),
        .cnt_o (ref_cnt)
    );

    for (genvar t = 0; t < 2; t++) begin : g_trig
        fdet_sat_counter #(.WIDTH(CNT_W)) trig_ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (restart_i),
            .inc_i (count_en & line_rise[LINE_UP + t]),
            .cnt_o (trig_cnt[t])
        );
    end

    fdet_verdict #(.WIDTH(CNT_W)) verdict_i (
        .up_cnt_i  (trig_cnt[0]),
        .dn_cnt_i  (trig_cnt[1]),
        .verdict_o (verdict)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (restart_i) begin
            st_d.active = 1'b1;
            st_d.fast   = 1'b0;
            st_d.slow   = 1'b0;
        end else if (st_q.active && win_full) begin
            st_d.active = 1'b0;
            st_d.done   = 1'b1;
            st_d.fast   = (verdict == VERDICT_FAST);
            st_d.slow   = (verdict == VERDICT_SLOW);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b1, done: 1'b0, fast: 1'b0, slow: 1'b0};
        else        st_q <= st_d;
    end

    assign fast_o = st_q.fast;
    assign slow_o = st_q.slow;
    assign done_o = st_q.done;

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fast_o && slow_o));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && st_q.active && win_full) |=> done_o);

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !restart_i) |=> $stable({fast_o, slow_o}) && !done_o);

    // R5
    tie_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && st_q.active && win_full && trig_cnt[0] == trig_cnt[1])
            |=> !fast_o && !slow_o);

    // R3
    fast_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && st_q.active && win_full && trig_cnt[0] > trig_cnt[1])
            |=> fast_o);

endmodule

// File: tb/fdet_window_top_tb_top.sv
module fdet_window_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 14;
    localparam int CNT_W      = 5;
    localparam int SAT        = (1 << CNT_W) - 1;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic ref_l = 1'b0, up_l = 1'b0, dn_l = 1'b0;
    logic fast, slow, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdet_window_top #(.WINDOW(WINDOW), .CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .ref_i     (ref_l),
        .up_trig_i (up_l),
        .dn_trig_i (dn_l),
        .fast_o    (fast),
        .slow_o    (slow),
        .done_o    (done)
    );

    // Behavioural reference model: input samples delayed in a queue,
    // integer tallies, verdict taken once the reference tally is full.
    bit   m_active = 1'b1, m_done = 1'b0, m_fast = 1'b0, m_slow = 1'b0;
    int   m_ref = 0, m_up = 0, m_dn = 0;
    bit [2:0] hist[$] = '{3'b000, 3'b000, 3'b000};

    always @(posedge clk) begin
        bit [2:0] now, older, rise;
        now = {dn_l, up_l, ref_l};
        if (!rst_n) begin
            m_active = 1; m_done = 0; m_fast = 0; m_slow = 0;
            m_ref = 0; m_up = 0; m_dn = 0;
            hist = '{3'b000, 3'b000, 3'b000};
        end else begin
            older = hist[0];
            rise  = hist[1] & ~older;
            void'(hist.pop_front());
            hist.push_back(now);
            if (restart) begin
                m_active = 1; m_done = 0; m_fast = 0; m_slow = 0;
                m_ref = 0; m_up = 0; m_dn = 0;
            end else begin
                m_done = 0;
                if (m_active && m_ref == WINDOW) begin
                    m_fast = (m_up > m_dn);
                    m_slow = (m_dn > m_up);
                    m_done = 1;
                    m_active = 0;
                end else if (m_active) begin
                    if (rise[0]) m_ref++;
                    if (rise[1] && m_up < SAT) m_up++;
                    if (rise[2] && m_dn < SAT) m_dn++;
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model (R2, R6 covered on every clock)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check("R2 model compare {fast,slow,done}", {fast, slow, done},
                  {m_fast, m_slow, m_done});
            if (done) done_seen++;
        end
        if (cyc > WATCHDOG) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_restart();
        @(negedge clk);
        restart = 1; ref_l = 0; up_l = 0; dn_l = 0;
        @(negedge clk);
        restart = 0;
        done_seen = 0;
    endtask

    // Each reference period is 8 clocks, high for the first 4.
    // nu/nd: trigger rising edges per period (at even cycles); hold: up held high.
    task automatic run(input int nu, input int nd, input bit hold, input int periods,
                       input int dn_hold_pulses);
        for (int p = 0; p < periods; p++) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                ref_l = (c < 4);
                up_l  = hold ? 1'b1 : ((c % 2 == 0) && (c / 2 < nu));
                dn_l  = ((c % 2 == 0) && (c / 2 < nd)) ||
                        (p < dn_hold_pulses && c == 3);
            end
        end
        @(negedge clk);
        ref_l = 0; up_l = 0; dn_l = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low while in reset
        check("R1 fast in reset", fast, 0);
        check("R1 slow in reset", slow, 0);
        check("R1 done in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 outputs after reset", {fast, slow, done}, 0);

        // R3: one up edge per period, no down edges
        do_restart();
        run(1, 0, 0, 16, 0);
        check("R3 fast after up-majority", fast, 1);
        check("R3 slow after up-majority", slow, 0);
        check("R2 single done per window", done_seen, 1);
        // R7: extra periods after the decision change nothing
        run(0, 3, 0, 16, 0);
        check("R7 flag held after more input", {fast, slow}, 2'b10);
        check("R7 no second done", done_seen, 1);

        // R8: restart clears flags
        do_restart();
        check("R8 flags cleared by restart", {fast, slow}, 0);

        // R4: down majority
        run(0, 1, 0, 16, 0);
        check("R4 slow after down-majority", {fast, slow}, 2'b01);
        check("R2 single done per window", done_seen, 1);

        // R5: tie
        do_restart();
        run(1, 1, 0, 16, 0);
        check("R5 tie gives neither flag", {fast, slow}, 0);
        check("R2 done on tie", done_seen, 1);

        // R9: up saturates at 31, down reaches 27; wrapping would say slow
        do_restart();
        run(3, 2, 0, 16, 0);
        check("R9 saturated up still wins", {fast, slow}, 2'b10);

        // R9: both saturate -> tie
        do_restart();
        run(4, 4, 0, 16, 0);
        check("R9 both saturated tie", {fast, slow}, 0);

        // R8: mid-window restart drops a burst of down edges
        do_restart();
        run(0, 3, 0, 6, 0);
        check("R8 no verdict before window end", done_seen, 0);
        do_restart();
        run(1, 0, 0, 16, 0);
        check("R8 stale counts dropped", {fast, slow}, 2'b10);

        // R10: up held high all window counts once, two down pulses win
        do_restart();
        run(0, 0, 1, 16, 2);
        check("R10 held level counts once", {fast, slow}, 2'b01);

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule